// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block takes one memory request from a 32-lane warp. The request carries a word address per lane, a lane-enable mask and one read/write mode for the whole request. Storage is split into 32 banks of 4-byte words, one bank for each value of the low address bits. A bank can do one read or one write per cycle. When several enabled lanes fall into one bank with different word addresses, the block replays the request over several cycles. Lanes that use the same word in a bank share a single access, so reading one word into many lanes costs no extra cycle.

The request is accepted while `busy` is low. The block then issues one access per touched bank on each replay cycle and shows which banks it drove and at which rows. On reads, it gathers the returned words into the lanes that asked for them. The request ends with a one-cycle `done` pulse together with the number of access cycles it took. Memory rows are inferred as one synchronous-read RAM per bank.

Top module: `shm_bank_serializer`

## Requirements
- R1: A lane's word address selects bank = address mod 32 (bits 4:0) and row = address bits 8:5. After each access cycle, `acc_bank` bit b is set exactly when bank b was accessed, and `acc_row` bits [4b+3:4b] give the row used.
- R2: When all enabled lanes fall in distinct banks, the request completes with `done_cycles` = 1.
- R3: `done_cycles` equals the largest number of distinct addresses that enabled lanes place in any single bank.
- R4: Enabled lanes that read the same address are served by one broadcast access and add no cycle. Each of those lanes receives the word.
- R5: Lane l using address 33*l (a column of a 32x32 array with row stride 33) takes one cycle.
- R6: In each replay cycle, a bank serves the address of its lowest-numbered lane that is still pending.
- R7: When several enabled lanes write the same address, the data of the highest-numbered of those lanes is stored.
- R8: Disabled lanes cause no access and no write. A request with an all-zero mask finishes with `done_cycles` = 0 and no bank activity.
- R9: `busy` rises on the cycle after acceptance and stays high until `done`. `req_valid` is ignored while `busy` is high.
- R10: After reset, `busy`, `done` and `acc_bank` are 0. `done` is a one-cycle pulse, and in that cycle every enabled lane of a read holds the word stored at its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_mask | input | 32 | Lane enables |
| req_addr | input | 288 | Word address per lane, 9 bits each, lane 0 lowest |
| req_wdata | input | 1024 | Write word per lane, 32 bits each |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| done_cycles | output | 6 | Access cycles used by the finished request |
| rd_data | output | 1024 | Gathered read word per lane |
| acc_bank | output | 32 | Banks accessed in the last cycle |
| acc_row | output | 128 | Row used per bank in the last cycle, 4 bits each |

## Verification
The hardest case to reach from the ports is a bank that holds a mix of duplicate and distinct addresses. In that case the replay length depends on distinct addresses only, not on the number of lanes. Strided patterns with power-of-two strides build 2-, 4-, 8- and 16-way conflicts. Alternating broadcast pairs mix sharing with conflicts. A two-lane request with its higher address on the lower lane exposes the replay order through `acc_row`. A second request held on `req_valid` during a long 16-cycle replay must leave memory untouched.

// File: rtl/shm_pkg.sv
package shm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACC   = 2'd1,
    ST_DRAIN = 2'd2
  } shm_state_e;
endpackage

// File: rtl/shm_bank_pick.sv
module shm_bank_pick #(
  parameter int LANES = 32,
  parameter int BW    = 5,
  parameter int RW    = 4,
  parameter int BANK  = 0,
  localparam int AW   = BW + RW,
  localparam int LW   = $clog2(LANES)
) (
  input  logic [LANES-1:0]    pend,
  input  logic [LANES*AW-1:0] addr_flat,
  output logic                hit,
  output logic [RW-1:0]       row,
  output logic [LANES-1:0]    served,
  output logic [LW-1:0]       wsel
);
  localparam logic [BW-1:0] BID = BW'(BANK);

  always_comb begin
    hit = 1'b0;
    row = '0;
    for (int l = 0; l < LANES; l++) begin
      if (!hit && pend[l] && addr_flat[l*AW +: BW] == BID) begin
        hit = 1'b1;
        row = addr_flat[l*AW+BW +: RW];
      end
    end
  end

  always_comb begin
    served = '0;
    wsel   = '0;
    for (int l = 0; l < LANES; l++) begin
      if (hit && pend[l] && addr_flat[l*AW +: AW] == {row, BID}) begin
        served[l] = 1'b1;
        wsel      = LW'(l);
      end
    end
  end
endmodule

// File: rtl/shm_bank_ram.sv
module shm_bank_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int RW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [RW-1:0] a,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[a] <= wd;
      else    rd     <= mem[a];
    end
  end
endmodule

// File: rtl/shm_bank_serializer.sv
module shm_bank_serializer
  import shm_pkg::*;
#(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int BW   = $clog2(BANKS),
  localparam int RW   = $clog2(DEPTH),
  localparam int AW   = BW + RW,
  localparam int LW   = $clog2(LANES),
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [LANES-1:0]    req_mask,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES*DW-1:0] req_wdata,
  output logic                busy,
  output logic                done,
  output logic [CW-1:0]       done_cycles,
  output logic [LANES*DW-1:0] rd_data,
  output logic [BANKS-1:0]    acc_bank,
  output logic [BANKS*RW-1:0] acc_row
);
  shm_state_e          st;
  logic [LANES-1:0]    pend, served_q, served_all;
  logic                wr_q;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES*DW-1:0] wd_q;
  logic [CW-1:0]       cnt;

  logic [BANKS-1:0]    hit_v;
  logic [RW-1:0]       row_a    [BANKS];
  logic [LANES-1:0]    served_a [BANKS];
  logic [LW-1:0]       wsel_a   [BANKS];
  logic [DW-1:0]       bank_rd  [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    shm_bank_pick #(.LANES(LANES), .BW(BW), .RW(RW), .BANK(b)) u_pick (
      .pend(pend), .addr_flat(addr_q), .hit(hit_v[b]), .row(row_a[b]),
      .served(served_a[b]), .wsel(wsel_a[b])
    );
    shm_bank_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
      .clk(clk), .en(st == ST_ACC && hit_v[b]), .we(wr_q), .a(row_a[b]),
      .wd(wd_q[wsel_a[b]*DW +: DW]), .rd(bank_rd[b])
    );
  end

  always_comb begin
    served_all = '0;
    for (int b = 0; b < BANKS; b++) served_all |= served_a[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      pend        <= '0;
      served_q    <= '0;
      wr_q        <= 1'b0;
      addr_q      <= '0;
      wd_q        <= '0;
      cnt         <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      done_cycles <= '0;
      rd_data     <= '0;
      acc_bank    <= '0;
      acc_row     <= '0;
    end else begin
      done     <= 1'b0;
      acc_bank <= '0;
      served_q <= '0;
      for (int l = 0; l < LANES; l++)
        if (served_q[l]) rd_data[l*DW +: DW] <= bank_rd[addr_q[l*AW +: BW]];
      case (st)
        ST_IDLE: if (req_valid) begin
          st     <= ST_ACC;
          busy   <= 1'b1;
          pend   <= req_mask;
          wr_q   <= req_write;
          addr_q <= req_addr;
          wd_q   <= req_wdata;
          cnt    <= '0;
        end
        ST_ACC: begin
          pend     <= pend & ~served_all;
          served_q <= wr_q ? '0 : served_all;
          acc_bank <= hit_v;
          for (int b = 0; b < BANKS; b++) acc_row[b*RW +: RW] <= row_a[b];
          if (pend != '0) cnt <= cnt + 1'b1;
          if ((pend & ~served_all) == '0) st <= ST_DRAIN;
        end
        ST_DRAIN: begin
          st          <= ST_IDLE;
          busy        <= 1'b0;
          done        <= 1'b1;
          done_cycles <= cnt;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_progress_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACC && pend != '0) |=> ($countones(pend) < $countones($past(pend))));
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= CW'(LANES)));
  p_done_not_busy_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_done_after_busy_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));
  p_mode_held_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || $stable(wr_q)));
  p_no_acc_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (acc_bank == '0));
endmodule

// File: tb/sim_shm_bank_serializer.sv
module sim_shm_bank_serializer;
  localparam int LANES = 32, BANKS = 32, DEPTH = 16, DW = 32;
  localparam int AW = 9, RW = 4, CW = 6, MW = BANKS * DEPTH;

  typedef struct packed {
    logic       w;
    logic [5:0] stride;
    logic [8:0] base;
    logic [5:0] cyc;
    logic [3:0] tag;
  } vec_t;

  localparam vec_t TBL [13] = '{
    '{1'b1, 6'd2,  9'd0,   6'd2,  4'd3},
    '{1'b0, 6'd2,  9'd1,   6'd2,  4'd3},
    '{1'b0, 6'd4,  9'd0,   6'd4,  4'd3},
    '{1'b1, 6'd8,  9'd3,   6'd8,  4'd3},
    '{1'b0, 6'd16, 9'd0,   6'd16, 4'd3},
    '{1'b0, 6'd1,  9'd64,  6'd1,  4'd2},
    '{1'b0, 6'd0,  9'd77,  6'd1,  4'd4},
    '{1'b0, 6'd33, 9'd0,   6'd1,  4'd5},
    '{1'b1, 6'd33, 9'd5,   6'd1,  4'd5},
    '{1'b0, 6'd33, 9'd5,   6'd1,  4'd5},
    '{1'b1, 6'd0,  9'd100, 6'd1,  4'd7},
    '{1'b0, 6'd0,  9'd100, 6'd1,  4'd4},
    '{1'b0, 6'd3,  9'd7,   6'd1,  4'd2}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [LANES-1:0] req_mask = '0;
  logic [LANES*AW-1:0] req_addr = '0;
  logic [LANES*DW-1:0] req_wdata = '0;
  logic busy, done;
  logic [CW-1:0] done_cycles;
  logic [LANES*DW-1:0] rd_data;
  logic [BANKS-1:0] acc_bank;
  logic [BANKS*RW-1:0] acc_row;

  logic [DW-1:0] shadow [MW];
  int n_chk = 0, n_fail = 0;
  int got_cyc;
  logic [BANKS-1:0] first_bank;
  logic [BANKS*RW-1:0] first_row;

  always #5 clk = ~clk;

  shm_bank_serializer u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_mask(req_mask), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .done_cycles(done_cycles), .rd_data(rd_data),
    .acc_bank(acc_bank), .acc_row(acc_row)
  );

  function automatic string tname(input int t);
    case (t)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      7: return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_lane(input int l, input int a, input logic [DW-1:0] d);
    req_addr[l*AW +: AW]   = AW'(a);
    req_wdata[l*DW +: DW]  = d;
  endtask

  // drives current req_* for one cycle, waits for done, checks data vs shadow
  task automatic run(input logic w, input logic [LANES-1:0] m);
    int k = 0;
    logic bad = 1'b0;
    req_write = w;
    req_mask  = m;
    req_valid = 1'b1;
    got_cyc   = -1;
    while (got_cyc < 0) begin
      @(negedge clk);
      k++;
      if (k == 1) req_valid = 1'b0;
      if (k == 2) begin first_bank = acc_bank; first_row = acc_row; end
      if (done) got_cyc = int'(done_cycles);
    end
    if (w) begin
      for (int l = 0; l < LANES; l++)
        if (m[l]) shadow[req_addr[l*AW +: AW]] = req_wdata[l*DW +: DW];
    end else begin
      for (int l = 0; l < LANES; l++)
        if (m[l] && rd_data[l*DW +: DW] != shadow[req_addr[l*AW +: AW]]) begin
          if (!bad) $display("FAIL R10 lane %0d read actual=%0h expected=%0h", l,
                             rd_data[l*DW +: DW], shadow[req_addr[l*AW +: AW]]);
          bad = 1'b1;
        end
      n_chk++;
      if (bad) n_fail++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy == 1'b0 && done == 1'b0 && acc_bank == '0, "R10 reset", {busy, done}, 0);
    rst = 1'b0;
    @(negedge clk);

    // fill whole memory, linear blocks: R1 and R2
    for (int blk = 0; blk < DEPTH; blk++) begin
      for (int l = 0; l < LANES; l++) set_lane(l, blk * 32 + l, 32'h5000_0000 + 32'(blk * 32 + l));
      run(1'b1, '1);
      chk(got_cyc == 1, "R2 linear cycles", got_cyc, 1);
      if (blk == 0) chk(first_bank == '1, "R1 banks touched", first_bank, 32'hFFFF_FFFF);
    end

    // table walk
    for (int v = 0; v < 13; v++) begin
      for (int l = 0; l < LANES; l++)
        set_lane(l, (int'(TBL[v].base) + l * int'(TBL[v].stride)) % MW,
                 {8'(8'hA0 + v), 8'(l), 16'(v * 37 + l)});
      run(TBL[v].w, '1);
      chk(got_cyc == int'(TBL[v].cyc), tname(int'(TBL[v].tag)), got_cyc, TBL[v].cyc);
      if (TBL[v].stride == 6'd4)
        chk(first_bank == 32'h1111_1111, "R1 stride4 banks", first_bank, 32'h1111_1111);
    end

    // R7: all lanes wrote 100 last in table; lane 31 data must remain
    for (int l = 0; l < LANES; l++) set_lane(l, 100, '0);
    run(1'b0, 32'h1);
    chk(rd_data[DW-1:0] == {8'(8'hA0 + 10), 8'd31, 16'(10 * 37 + 31)}, "R7 highest lane wins",
        rd_data[DW-1:0], {8'(8'hA0 + 10), 8'd31, 16'(10 * 37 + 31)});

    // R6: lane0 at row 1, lane1 at row 0, same bank 0
    set_lane(0, 32, '0);
    set_lane(1, 0, '0);
    run(1'b0, 32'h3);
    chk(got_cyc == 2, "R6 cycles", got_cyc, 2);
    chk(first_row[RW-1:0] == 4'd1 && first_bank == 32'h1, "R6 lowest lane first", first_row[RW-1:0], 1);

    // R4 mixed broadcast: even lanes addr 5, odd lanes addr 37
    for (int l = 0; l < LANES; l++) set_lane(l, (l % 2 == 0) ? 5 : 37, '0);
    run(1'b0, '1);
    chk(got_cyc == 2, "R4 pairs of broadcast", got_cyc, 2);

    // R8: empty mask
    run(1'b0, '0);
    chk(got_cyc == 0 && first_bank == '0, "R8 empty mask", got_cyc, 0);

    // R8: disabled lane 5 not written
    for (int l = 0; l < LANES; l++) set_lane(l, 200 + l, 32'hBAD0_0000 + 32'(l));
    run(1'b1, ~32'h20);
    for (int l = 0; l < LANES; l++) set_lane(l, 200 + l, '0);
    run(1'b0, 32'h20);
    chk(rd_data[5*DW +: DW] == shadow[205], "R8 disabled lane write", rd_data[5*DW +: DW], shadow[205]);

    // R9: long read, then a write held on req_valid while busy
    for (int l = 0; l < LANES; l++) set_lane(l, (l * 16) % MW, '0);
    req_write = 1'b0;
    req_mask  = '1;
    req_valid = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R9 busy after accept", busy, 1);
    for (int l = 0; l < LANES; l++) set_lane(l, 7, 32'hDEAD_BEEF);
    req_write = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b1, "R9 busy during replay", busy, 1);
    req_valid = 1'b0;
    begin
      int w = 0;
      while (!done && w < 40) begin @(negedge clk); w++; end
    end
    chk(done_cycles == 6'd16, "R3 16-way", done_cycles, 16);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R10 done one cycle", {done, busy}, 0);
    for (int l = 0; l < LANES; l++) set_lane(l, 7, '0);
    run(1'b0, 32'h1);
    chk(rd_data[DW-1:0] == shadow[7], "R9 held request ignored", rd_data[DW-1:0], shadow[7]);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule